// File: doc/BRIEF.md
# Fixed-Priority Shared Bus Interconnect

This block joins several bus masters to a set of memory-mapped slaves through a single shared address, write-data and write-enable path. In the intended system the masters are, from most to least urgent, a program loader, a debug access port, the load/store port of the execute stage, and the instruction fetch port. Each cycle a purely combinational fixed-priority arbiter picks one requesting master. That master's address and write data are forwarded to every slave. The upper address nibble names the target slave.

Only the addressed slave sees the write strobe. Its read data travels back to the winning master only. When no attached slave answers to the nibble, the access reads zero and its write is dropped. While any master other than instruction fetch owns the bus, a hold output tells the core pipeline to freeze. Two things follow from this: a loader can replace the program at any point, and a load or store completes before the pipeline moves on.

Top module: `prio_bus_xbar`

## Requirements
- R1: At most one bit of `m_gnt` is set, and it belongs to the requesting master with the lowest index. Index 0 is the loader, 1 is debug, 2 is execute load/store, and the last index is instruction fetch.
- R2: With no request asserted, `m_gnt`, `s_we`, `s_addr`, `s_wdata`, `hold` and every `m_rdata` slice are all zero.
- R3: `s_addr` and `s_wdata` equal the address and write data of the granted master, taken from slice `m*ADDR_W` and slice `m*DATA_W` respectively.
- R4: Slave k receives a write strobe only when the granted master has its write enable high and bits [ADDR_W-1 -: 4] of its address equal k. All other `s_we` bits stay low.
- R5: A nibble value of `NUM_SLAVES` or more selects no slave: no `s_we` bit rises and the granted master reads zero.
- R6: The granted master's `m_rdata` slice carries slice k of `s_rdata`, where k is the selected slave. Every master that is not granted reads zero.
- R7: `hold` is high exactly when some master other than instruction fetch is granted.
- R8: A loader request is granted and raises `hold` whatever the other masters request and wherever they point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_req | input | NUM_MASTERS | Per-master bus request |
| m_we | input | NUM_MASTERS | Per-master write enable |
| m_addr | input | NUM_MASTERS*ADDR_W | Packed per-master address, master m at slice m |
| m_wdata | input | NUM_MASTERS*DATA_W | Packed per-master write data |
| m_gnt | output | NUM_MASTERS | One-hot grant |
| m_rdata | output | NUM_MASTERS*DATA_W | Packed per-master read data |
| s_addr | output | ADDR_W | Shared address to slaves |
| s_wdata | output | DATA_W | Shared write data to slaves |
| s_we | output | NUM_SLAVES | Per-slave write strobe |
| s_rdata | input | NUM_SLAVES*DATA_W | Packed per-slave read data |
| hold | output | 1 | Pipeline freeze while a non-fetch master owns the bus |

## Verification
The bench sweeps all sixteen request patterns, every write-enable pattern and all sixteen nibble values. Each master points at a different nibble, so a design that routed data from the wrong master or the wrong slave returns a value that the bench can tell apart from the right one. Nibbles past the last slave catch two faults: a decoder that wraps, which would strobe a real slave, and a read return that leaks a stale slave's data. Cases where only fetch requests, or where fetch requests alongside others, show whether `hold` is tied to the wrong master. Both arbiter variants and both read-return variants are checked against the same expected values.

// File: rtl/prio_bus_pkg.sv
package prio_bus_pkg;

   // Way of finding the lowest-index requester.
   typedef enum logic {
      ARB_SCAN = 1'b0,   // priority loop
      ARB_TWOS = 1'b1    // isolate lowest set bit by two's complement
   } arb_style_e;

   // Way of steering slave read data back to the winner.
   typedef enum logic {
      RET_ANDOR = 1'b0,  // AND-OR over per-slave compares
      RET_INDEX = 1'b1   // indexed table padded to the full nibble span
   } ret_style_e;

   // Conventional roles of master slots (lowest index wins).
   localparam int unsigned MST_LOADER = 0;
   localparam int unsigned MST_DEBUG  = 1;
   localparam int unsigned MST_LSU    = 2;

endpackage

// File: rtl/prio_pick.sv
module prio_pick
   import prio_bus_pkg::*;
#(
   parameter int unsigned N     = 4,
   parameter arb_style_e  STYLE = ARB_SCAN,
   localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  gnt_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);

   generate
      if (STYLE == ARB_TWOS) begin : g_twos
         assign gnt_o = req_i & (~req_i + N'(1));
      end else begin : g_scan
         always_comb begin
            gnt_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) begin
                  gnt_o    = '0;
                  gnt_o[i] = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt_o[i]) idx_o = idx_o | IW'(i);
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/master_fwd.sv
module master_fwd #(
   parameter int unsigned NM = 4,
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic [NM-1:0]    gnt_i,
   input  logic [NM-1:0]    we_i,
   input  logic [NM*AW-1:0] addr_i,
   input  logic [NM*DW-1:0] wdata_i,
   output logic [AW-1:0]    addr_o,
   output logic [DW-1:0]    wdata_o,
   output logic             we_o
);

   always_comb begin
      addr_o  = '0;
      wdata_o = '0;
      we_o    = 1'b0;
      for (int m = 0; m < NM; m++) begin
         addr_o  = addr_o  | (addr_i[m*AW +: AW]  & {AW{gnt_i[m]}});
         wdata_o = wdata_o | (wdata_i[m*DW +: DW] & {DW{gnt_i[m]}});
         we_o    = we_o    | (we_i[m] & gnt_i[m]);
      end
   end

endmodule

// File: rtl/slave_sel.sv
module slave_sel #(
   parameter int unsigned SEL_W = 4,
   parameter int unsigned NS    = 6
) (
   input  logic [SEL_W-1:0] nib_i,
   output logic [NS-1:0]    hit_o
);

   genvar s;
   generate
      for (s = 0; s < NS; s++) begin : g_hit
         assign hit_o[s] = (nib_i == SEL_W'(s));
      end
   endgenerate

endmodule

// File: rtl/resp_ret.sv
module resp_ret
   import prio_bus_pkg::*;
#(
   parameter int unsigned NM    = 4,
   parameter int unsigned NS    = 6,
   parameter int unsigned DW    = 32,
   parameter int unsigned SEL_W = 4,
   parameter ret_style_e  STYLE = RET_ANDOR
) (
   input  logic [NS*DW-1:0] s_rdata_i,
   input  logic [SEL_W-1:0] nib_i,
   input  logic [NM-1:0]    gnt_i,
   output logic [NM*DW-1:0] m_rdata_o
);

   localparam int unsigned SPAN = 1 << SEL_W;

   logic [DW-1:0] picked;

   generate
      if (STYLE == RET_INDEX) begin : g_index
         logic [DW-1:0] tbl [SPAN];
         for (genvar k = 0; k < SPAN; k++) begin : g_tbl
            if (k < NS) begin : g_live
               assign tbl[k] = s_rdata_i[k*DW +: DW];
            end else begin : g_void
               assign tbl[k] = '0;
            end
         end
         assign picked = tbl[nib_i];
      end else begin : g_andor
         always_comb begin
            picked = '0;
            for (int s = 0; s < NS; s++) begin
               picked = picked |
                        (s_rdata_i[s*DW +: DW] & {DW{nib_i == SEL_W'(s)}});
            end
         end
      end
   endgenerate

   genvar m;
   generate
      for (m = 0; m < NM; m++) begin : g_ret
         assign m_rdata_o[m*DW +: DW] = gnt_i[m] ? picked : '0;
      end
   endgenerate

endmodule

// File: rtl/prio_bus_xbar.sv
module prio_bus_xbar
   import prio_bus_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 4,
   parameter int unsigned NUM_SLAVES  = 6,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SEL_W       = 4,
   parameter arb_style_e  ARB_STYLE   = ARB_SCAN,
   parameter ret_style_e  RET_STYLE   = RET_ANDOR
) (
   input  logic [NUM_MASTERS-1:0]        m_req,
   input  logic [NUM_MASTERS-1:0]        m_we,
   input  logic [NUM_MASTERS*ADDR_W-1:0] m_addr,
   input  logic [NUM_MASTERS*DATA_W-1:0] m_wdata,
   output logic [NUM_MASTERS-1:0]        m_gnt,
   output logic [NUM_MASTERS*DATA_W-1:0] m_rdata,
   output logic [ADDR_W-1:0]             s_addr,
   output logic [DATA_W-1:0]             s_wdata,
   output logic [NUM_SLAVES-1:0]         s_we,
   input  logic [NUM_SLAVES*DATA_W-1:0]  s_rdata,
   output logic                          hold
);

   localparam int unsigned IDX_W     = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
   localparam int unsigned FETCH_IDX = NUM_MASTERS - 1;
   localparam int unsigned SEL_SPAN  = 1 << SEL_W;

   generate
      if (NUM_MASTERS < 2) begin : g_chk_nm
         $error("prio_bus_xbar: at least two masters are needed");
      end
      if (SEL_W < 1 || SEL_W > ADDR_W) begin : g_chk_sel
         $error("prio_bus_xbar: SEL_W must lie within the address");
      end
      if (NUM_SLAVES < 1 || NUM_SLAVES > SEL_SPAN) begin : g_chk_ns
         $error("prio_bus_xbar: slave count exceeds the select span");
      end
   endgenerate

   logic [IDX_W-1:0] win_idx;
   logic             win_any;
   logic             fwd_we;
   logic [SEL_W-1:0] sel_nib;
   logic [NUM_SLAVES-1:0] slave_hit;

   prio_pick #(
      .N     (NUM_MASTERS),
      .STYLE (ARB_STYLE)
   ) u_pick (
      .req_i (m_req),
      .gnt_o (m_gnt),
      .idx_o (win_idx),
      .any_o (win_any)
   );

   master_fwd #(
      .NM (NUM_MASTERS),
      .AW (ADDR_W),
      .DW (DATA_W)
   ) u_fwd (
      .gnt_i   (m_gnt),
      .we_i    (m_we),
      .addr_i  (m_addr),
      .wdata_i (m_wdata),
      .addr_o  (s_addr),
      .wdata_o (s_wdata),
      .we_o    (fwd_we)
   );

   assign sel_nib = s_addr[ADDR_W-1 -: SEL_W];

   slave_sel #(
      .SEL_W (SEL_W),
      .NS    (NUM_SLAVES)
   ) u_sel (
      .nib_i (sel_nib),
      .hit_o (slave_hit)
   );

   assign s_we = fwd_we ? slave_hit : '0;

   resp_ret #(
      .NM    (NUM_MASTERS),
      .NS    (NUM_SLAVES),
      .DW    (DATA_W),
      .SEL_W (SEL_W),
      .STYLE (RET_STYLE)
   ) u_ret (
      .s_rdata_i (s_rdata),
      .nib_i     (sel_nib),
      .gnt_i     (m_gnt),
      .m_rdata_o (m_rdata)
   );

   assign hold = win_any && (win_idx != IDX_W'(FETCH_IDX));

endmodule

// File: rtl/prio_bus_chk.sv
module prio_bus_chk #(
   parameter int unsigned NUM_MASTERS = 4,
   parameter int unsigned NUM_SLAVES  = 6,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SEL_W       = 4
) (
   input logic [NUM_MASTERS-1:0]        m_req,
   input logic [NUM_MASTERS-1:0]        m_we,
   input logic [NUM_MASTERS-1:0]        m_gnt,
   input logic [NUM_MASTERS*DATA_W-1:0] m_rdata,
   input logic [ADDR_W-1:0]             s_addr,
   input logic [NUM_SLAVES-1:0]         s_we,
   input logic                          hold
);

   always_comb begin
      assert_one_grant_R1: assert ($onehot0(m_gnt));
      assert_grant_needs_req_R2: assert ((m_gnt & ~m_req) == '0);
      assert_req_gets_grant_R2: assert ((|m_req) == (|m_gnt));
      assert_single_strobe_R4: assert ($onehot0(s_we));
      assert_strobe_source_R4: assert (!(|s_we) || (|(m_gnt & m_we)));
      assert_hold_owner_R7: assert (hold == ((|m_gnt) && !m_gnt[NUM_MASTERS-1]));
      if (32'(s_addr[ADDR_W-1 -: SEL_W]) >= NUM_SLAVES) begin
         assert_unmapped_quiet_R5: assert (s_we == '0);
      end
      for (int m = 0; m < NUM_MASTERS; m++) begin
         if (!m_gnt[m]) begin
            assert_idle_rdata_R6: assert (m_rdata[m*DATA_W +: DATA_W] == '0);
         end
         for (int j = 0; j < m; j++) begin
            if (m_gnt[m]) begin
               assert_lowest_wins_R1: assert (!m_req[j]);
            end
         end
      end
      if (m_req[0]) begin
         assert_loader_first_R8: assert (m_gnt[0] && hold);
      end
   end

endmodule

bind prio_bus_xbar prio_bus_chk #(
   .NUM_MASTERS (NUM_MASTERS),
   .NUM_SLAVES  (NUM_SLAVES),
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .SEL_W       (SEL_W)
) u_chk (
   .m_req   (m_req),
   .m_we    (m_we),
   .m_gnt   (m_gnt),
   .m_rdata (m_rdata),
   .s_addr  (s_addr),
   .s_we    (s_we),
   .hold    (hold)
);

// File: tb/prio_bus_xbar_test.sv
module prio_bus_xbar_test;
   import prio_bus_pkg::*;

   localparam int NM = 4;
   localparam int NS = 6;
   localparam int AW = 32;
   localparam int DW = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [NM-1:0]    req, we;
   logic [NM*AW-1:0] maddr;
   logic [NM*DW-1:0] mwdata;
   logic [NS*DW-1:0] srd;

   logic [NM-1:0]    gnt_a, gnt_b;
   logic [NM*DW-1:0] rd_a, rd_b;
   logic [AW-1:0]    sa_a, sa_b;
   logic [DW-1:0]    sw_a, sw_b;
   logic [NS-1:0]    swe_a, swe_b;
   logic             hold_a, hold_b;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   prio_bus_xbar #(
      .NUM_MASTERS(NM), .NUM_SLAVES(NS), .ADDR_W(AW), .DATA_W(DW), .SEL_W(4),
      .ARB_STYLE(ARB_SCAN), .RET_STYLE(RET_ANDOR)
   ) uut (
      .m_req(req), .m_we(we), .m_addr(maddr), .m_wdata(mwdata),
      .m_gnt(gnt_a), .m_rdata(rd_a), .s_addr(sa_a), .s_wdata(sw_a),
      .s_we(swe_a), .s_rdata(srd), .hold(hold_a)
   );

   prio_bus_xbar #(
      .NUM_MASTERS(NM), .NUM_SLAVES(NS), .ADDR_W(AW), .DATA_W(DW), .SEL_W(4),
      .ARB_STYLE(ARB_TWOS), .RET_STYLE(RET_INDEX)
   ) uut_alt (
      .m_req(req), .m_we(we), .m_addr(maddr), .m_wdata(mwdata),
      .m_gnt(gnt_b), .m_rdata(rd_b), .s_addr(sa_b), .s_wdata(sw_b),
      .s_we(swe_b), .s_rdata(srd), .hold(hold_b)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] slave_word(input int s);
      return 32'hA500_0000 + DW'(s) * 32'h0001_0203;
   endfunction

   function automatic logic [AW-1:0] master_addr(input int m, input int nib);
      return {4'(nib), 28'h000_0100 + 28'(m) * 28'h10};
   endfunction

   function automatic logic [DW-1:0] master_data(input int m, input int nib);
      return 32'h5A00_0000 + DW'(m) * 32'h11 + DW'(nib);
   endfunction

   task automatic check_one(input string who,
                            input logic [NM-1:0] g, input logic [NM*DW-1:0] rd,
                            input logic [AW-1:0] sa, input logic [DW-1:0] sw,
                            input logic [NS-1:0] swe, input logic h,
                            input int r, input int n, input int w);
      int gi = -1;
      int snib;
      logic [NM-1:0] eg = '0;
      logic [NS-1:0] ewe = '0;
      logic [DW-1:0] pick = '0;
      for (int m = NM - 1; m >= 0; m--) if (r[m]) gi = m;
      if (gi >= 0) eg[gi] = 1'b1;
      snib = (gi >= 0) ? ((n + gi) % 16) : 0;
      if (gi >= 0 && snib < NS && w[gi]) ewe[snib] = 1'b1;
      if (gi >= 0 && snib < NS) pick = slave_word(snib);

      chk({who, " R1 grant"}, 64'(g), 64'(eg));
      chk({who, " R7 hold"}, 64'(h), 64'(gi >= 0 && gi != NM - 1));
      if (gi < 0) begin
         chk({who, " R2 idle addr"}, 64'(sa), 64'(0));
         chk({who, " R2 idle wdata"}, 64'(sw), 64'(0));
         chk({who, " R2 idle strobe"}, 64'(swe), 64'(0));
      end else begin
         chk({who, " R3 addr"}, 64'(sa), 64'(master_addr(gi, (n + gi) % 16)));
         chk({who, " R3 wdata"}, 64'(sw), 64'(master_data(gi, (n + gi) % 16)));
         if (snib >= NS) chk({who, " R5 unmapped strobe"}, 64'(swe), 64'(0));
         else            chk({who, " R4 strobe"}, 64'(swe), 64'(ewe));
      end
      for (int m = 0; m < NM; m++) begin
         if (m == gi && snib >= NS)
            chk({who, " R5 unmapped read"}, 64'(rd[m*DW +: DW]), 64'(0));
         else
            chk({who, " R6 read"}, 64'(rd[m*DW +: DW]),
                64'((m == gi) ? pick : '0));
      end
      if (r[0]) chk({who, " R8 loader wins"}, 64'({g[0], h}), 64'(2'b11));
   endtask

   initial begin
      req = '0; we = '0; maddr = '0; mwdata = '0;
      for (int s = 0; s < NS; s++) srd[s*DW +: DW] = slave_word(s);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // quiescent state: nothing requested
      chk("R2 idle grant", 64'(gnt_a), 64'(0));
      chk("R2 idle hold", 64'(hold_a), 64'(0));
      chk("R2 idle rdata", 64'(rd_a[DW-1:0]), 64'(0));

      for (int r = 0; r < 16; r++) begin
         for (int n = 0; n < 16; n++) begin
            for (int w = 0; w < 16; w++) begin
               @(posedge clk);
               #1;
               req = 4'(r);
               we  = 4'(w);
               for (int m = 0; m < NM; m++) begin
                  maddr[m*AW +: AW]  = master_addr(m, (n + m) % 16);
                  mwdata[m*DW +: DW] = master_data(m, (n + m) % 16);
               end
               @(negedge clk);
               check_one("base", gnt_a, rd_a, sa_a, sw_a, swe_a, hold_a, r, n, w);
               check_one("alt",  gnt_b, rd_b, sa_b, sw_b, swe_b, hold_b, r, n, w);
            end
         end
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule